// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This block takes a downstream programmable device through a parallel configuration load. It is driven by a start command that carries the image size in bytes. It pulses the active-low program line for a fixed number of cycles, then waits for the device's init sense line to rise, which shows that the configuration memory has been cleared. It then moves the image bytes from a ready/valid byte source onto a byte-wide configuration bus, with one write strobe per byte. Last, it waits for the done sense line to rise.

Each wait has its own cycle limit. A load ends with a one-cycle finish pulse that carries a two-bit result code. If the configuration space is flagged as absent when the start command arrives, the sequencer answers at once with an abort code and leaves every control line alone. An optional enable output is held high for as long as a load is in progress.

The init and done lines are asynchronous to the block. Each passes through a two-flop synchronizer before the sequencer looks at it.

Top module: `cfg_load_seq`

## Requirements
- R1: When the enable option is configured, `cfg_en_o` is high in exactly the cycles where `busy_o` is high, and low on every exit, whatever the result.
- R2: After an accepted start, `cfg_prog_n_o` is low for exactly PROG_LOW_CYC consecutive cycles, beginning in the cycle after the start. It is high at all other times.
- R3: Init and done are each sampled through two flip-flops. `s_ready_o` first rises on the third rising clock edge after init goes high during the init wait.
- R4: If synchronised init is still low after INIT_TMO cycles of waiting, the load ends with result 2. The finish pulse comes PROG_LOW_CYC + INIT_TMO cycles after the start edge, and no byte is taken.
- R5: Bytes are accepted only while the sequencer is streaming and bytes remain. Each accepted byte appears on `cfg_data_o`, with `cfg_wr_o` high for one cycle, in the cycle after it is accepted. Bytes leave in arrival order, and exactly `size_i` bytes are written.
- R6: Cycles where `s_valid_i` is low produce no write strobe, and the byte order is kept across such gaps.
- R7: If synchronised done is still low after DONE_TMO cycles of waiting after the last byte, the load ends with result 3.
- R8: If done rises within its limit, the load ends with result 0.
- R9: A start while `space_present_i` is low gives a finish pulse with result 1 in the next cycle. In that case `busy_o` stays low, the program line stays high and enable stays low.
- R10: `finish_o` is high for exactly one cycle per load. In that cycle `busy_o` is already low and `result_o` holds the code (0 ok, 1 no space, 2 init timeout, 3 done timeout).
- R11: A start while `busy_o` is high is ignored: the load in progress keeps its size and gives one finish. A start in the finish cycle itself is accepted.
- R12: A size of zero writes no byte and goes straight on to the done wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| size_i | input | SIZE_W | Image length in bytes, taken with start |
| space_present_i | input | 1 | High when a configuration space exists |
| s_valid_i | input | 1 | Source byte valid |
| s_data_i | input | DATA_W | Source byte |
| s_ready_o | output | 1 | Sequencer takes a byte this cycle |
| cfg_data_o | output | DATA_W | Configuration data bus |
| cfg_wr_o | output | 1 | One-cycle write strobe per byte |
| cfg_en_o | output | 1 | Optional device enable, high during a load |
| cfg_prog_n_o | output | 1 | Program line, active low |
| init_i | input | 1 | Init sense from the device (asynchronous) |
| done_i | input | 1 | Done sense from the device (asynchronous) |
| busy_o | output | 1 | Load in progress |
| finish_o | output | 1 | One-cycle end-of-load pulse |
| result_o | output | 2 | Result code, valid with finish_o |

## Verification
Two events can land on the same clock edge. One is the finish of a load, which is the return to idle. The other is the arrival of the next start command. The bench sees the finish pulse and raises start in that same cycle. It then expects the new load to be accepted: busy high and the program line low from the next cycle, and a second finish with its own result. A stray start is also placed inside the program pulse. The scoreboard then has to see exactly the first command's bytes and a single finish for that load.

// File: rtl/cfg_load_pkg.sv
// Package: shared types of the configuration load sequencer.
// Assumes nothing beyond the two enumerations below.
package cfg_load_pkg;

    // Sequencer phases, walked in this fixed order.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PULSE     = 3'd1,
        ST_WAIT_INIT = 3'd2,
        ST_STREAM    = 3'd3,
        ST_WAIT_DONE = 3'd4
    } seq_state_t;

    // Result codes reported with the finish pulse.
    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_NO_SPACE = 2'd1,
        RES_NO_INIT  = 2'd2,
        RES_NO_DONE  = 2'd3
    } load_result_t;

endpackage

// File: rtl/cfg_sync2.sv
// Module: cfg_sync2
// Two-flop synchronizer for a vector of independent slow-moving
// asynchronous sense lines. Assumes each bit is a level that
// stays put for several cycles, so bits need no mutual coherence.
module cfg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages per bit; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/cfg_cycle_timer.sv
// Module: cfg_cycle_timer
// Shared cycle counter for the pulse width and both timeouts.
// Clear wins over count. Assumes the caller compares count_o
// against a limit below 2**W and leaves the phase before wrap.
module cfg_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_q;

    // Count enabled cycles; restart at every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (en_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // A phase must never sit long enough to roll the counter over.
    assert_timer_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && (&cnt_q)) |=> 1'b0)
        else $error("cycle timer wrapped");

endmodule

// File: rtl/cfg_stream_port.sv
// Module: cfg_stream_port
// Byte mover between the ready/valid source and the configuration bus.
// Holds the count of bytes still owed, which is loaded at start.
// Registers data and strobe, so each byte shows up one cycle
// after it is accepted. Assumes load_i only pulses while the
// sequencer is idle.
module cfg_stream_port #(
    parameter int DATA_W = 8,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              active_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    output logic              s_ready_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_wr_o,
    output logic              empty_o
);

    logic [SIZE_W-1:0] remain_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_q;
    logic              take;

    assign empty_o   = (remain_q == '0);
    assign s_ready_o = active_i && !empty_o;
    assign take      = s_ready_o && s_valid_i;

    // Remaining byte count: loaded with the size, lowered per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      remain_q <= '0;
        else if (load_i) remain_q <= size_i;
        else if (take)   remain_q <= remain_q - 1'b1;
    end

    // Output register for the configuration bus and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            wr_q <= take;
            if (take) data_q <= s_data_i;
        end
    end

    assign cfg_data_o = data_q;
    assign cfg_wr_o   = wr_q;

    // Every strobe traces back to a handshake in the previous cycle.
    assert_strobe_follows_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> $past(s_valid_i && s_ready_o))
        else $error("strobe without accepted byte");

    // Nothing is accepted once the owed count reaches zero.
    assert_no_take_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !load_i) |=> !cfg_wr_o || $past(take))
        else $error("byte taken beyond size");

endmodule

// File: rtl/cfg_load_seq.sv
// Module: cfg_load_seq (top)
// Walks a programmable device through a parallel configuration load:
// program pulse, init wait, byte stream, done wait, coded finish.
// Assumes PROG_LOW_CYC >= 3, so the synchronised init has dropped
// before the init wait begins, and that the limits are at least 1.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SIZE_W       = 24,
    parameter int PROG_LOW_CYC = 20,
    parameter int INIT_TMO     = 10_000_000,
    parameter int DONE_TMO     = 100_000_000,
    parameter bit ENABLE_USED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              space_present_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    output logic              s_ready_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_wr_o,
    output logic              cfg_en_o,
    output logic              cfg_prog_n_o,
    input  logic              init_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic [1:0]        result_o
);

    localparam int LIM_A   = (PROG_LOW_CYC > INIT_TMO) ? PROG_LOW_CYC : INIT_TMO;
    localparam int LIM_MAX = (LIM_A > DONE_TMO) ? LIM_A : DONE_TMO;
    localparam int TMR_W   = $clog2(LIM_MAX) + 1;
    localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PROG_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] INIT_END  = TMR_W'(INIT_TMO - 1);
    localparam logic [TMR_W-1:0] DONE_END  = TMR_W'(DONE_TMO - 1);

    seq_state_t   state_q, state_d;
    load_result_t result_q, result_d;
    logic         fin_q, fin_d;
    logic [1:0]   sense_s;
    logic         init_s, done_s;
    logic [TMR_W-1:0] tcount;
    logic         start_acc;
    logic         stream_empty;

    // Sense lines brought into the clock domain.
    cfg_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_i}),
        .sync_o  (sense_s)
    );
    assign init_s = sense_s[0];
    assign done_s = sense_s[1];

    // One timer, restarted on every phase change.
    cfg_cycle_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_d != state_q),
        .en_i    (busy_o),
        .count_o (tcount)
    );

    assign start_acc = (state_q == ST_IDLE) && start_i && space_present_i;

    cfg_stream_port #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_acc),
        .size_i     (size_i),
        .active_i   (state_q == ST_STREAM),
        .s_valid_i  (s_valid_i),
        .s_data_i   (s_data_i),
        .s_ready_o  (s_ready_o),
        .cfg_data_o (cfg_data_o),
        .cfg_wr_o   (cfg_wr_o),
        .empty_o    (stream_empty)
    );

    // Next-phase and result decision.
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        fin_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!space_present_i) begin
                        fin_d    = 1'b1;
                        result_d = RES_NO_SPACE;
                    end else begin
                        state_d = ST_PULSE;
                    end
                end
            end
            ST_PULSE: begin
                if (tcount == PULSE_END) state_d = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    state_d = ST_STREAM;
                end else if (tcount == INIT_END) begin
                    state_d  = ST_IDLE;
                    fin_d    = 1'b1;
                    result_d = RES_NO_INIT;
                end
            end
            ST_STREAM: begin
                if (stream_empty) state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done_s) begin
                    state_d  = ST_IDLE;
                    fin_d    = 1'b1;
                    result_d = RES_OK;
                end else if (tcount == DONE_END) begin
                    state_d  = ST_IDLE;
                    fin_d    = 1'b1;
                    result_d = RES_NO_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase, finish pulse and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= RES_OK;
            fin_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            fin_q    <= fin_d;
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign cfg_prog_n_o = (state_q != ST_PULSE);
    assign finish_o     = fin_q;
    assign result_o     = result_q;

    // Enable output exists only when the option is configured.
    if (ENABLE_USED) begin : g_en
        assign cfg_en_o = busy_o;
    end else begin : g_no_en
        assign cfg_en_o = 1'b0;
    end

    // Enable drops on every exit path.
    assert_en_off_at_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> !cfg_en_o)
        else $error("enable still high at finish");

    // Program line is only ever low inside a load.
    assert_prog_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n_o |-> busy_o && cfg_en_o == ENABLE_USED)
        else $error("program low outside a load");

    // Bytes are taken only after the program pulse is over.
    assert_ready_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> busy_o && cfg_prog_n_o)
        else $error("byte ready outside streaming");

    // The abort leaves every control line untouched.
    assert_nospace_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && result_o == RES_NO_SPACE) |-> cfg_prog_n_o && !cfg_en_o && !busy_o
                                                   && !$past(busy_o))
        else $error("abort touched control lines");

    // Finish is a single-cycle pulse, never while busy.
    assert_finish_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !finish_o)
        else $error("finish longer than a cycle");

    assert_finish_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> !busy_o)
        else $error("finish while busy");

endmodule

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;

    localparam int DATA_W = 8;
    localparam int SIZE_W = 8;
    localparam int PROG   = 5;
    localparam int ITMO   = 40;
    localparam int DTMO   = 60;
    localparam int IDLY   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [SIZE_W-1:0] size_i = '0;
    logic space_present_i = 1'b1;
    logic s_valid_i = 1'b0;
    logic [DATA_W-1:0] s_data_i = '0;
    logic s_ready_o;
    logic [DATA_W-1:0] cfg_data_o;
    logic cfg_wr_o, cfg_en_o, cfg_prog_n_o;
    logic init_i = 1'b0;
    logic done_i = 1'b0;
    logic busy_o, finish_o;
    logic [1:0] result_o;

    always #2 clk = ~clk;

    cfg_load_seq #(
        .DATA_W(DATA_W), .SIZE_W(SIZE_W), .PROG_LOW_CYC(PROG),
        .INIT_TMO(ITMO), .DONE_TMO(DTMO), .ENABLE_USED(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .space_present_i(space_present_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
        .s_ready_o(s_ready_o), .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o),
        .cfg_en_o(cfg_en_o), .cfg_prog_n_o(cfg_prog_n_o), .init_i(init_i),
        .done_i(done_i), .busy_o(busy_o), .finish_o(finish_o), .result_o(result_o)
    );

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    logic [1:0]        res_q[$];
    int strobe_cnt = 0, fin_cnt = 0, ready_cnt = 0, en_bad = 0, cyc = 0;
    int low_run = 0, init_rise_cyc = -1;
    logic init_prev = 1'b0, ready_prev = 1'b0, prog_prev = 1'b1;
    bit init_ena = 1'b1, done_go = 1'b0;
    int ictr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Device model: init and done react to the program line.
    always @(negedge clk) begin
        #1;
        if (!cfg_prog_n_o) begin
            init_i = 1'b0;
            done_i = 1'b0;
            ictr   = 0;
        end else begin
            if (init_ena) begin
                if (ictr >= IDLY) init_i = 1'b1;
                else ictr++;
            end
            if (done_go) done_i = 1'b1;
        end
    end

    // Monitor: scoreboard pops and the cycle-level observations.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cfg_en_o != busy_o) en_bad++;
            if (cfg_wr_o) begin
                strobe_cnt++;
                if (exp_q.size() == 0)
                    check(1'b0, "R5 unexpected strobe", int'(cfg_data_o), -1);
                else begin
                    automatic logic [DATA_W-1:0] e = exp_q.pop_front();
                    check(cfg_data_o == e, "R5/R6 byte order", int'(cfg_data_o), int'(e));
                end
            end
            if (finish_o) begin
                fin_cnt++;
                if (res_q.size() == 0)
                    check(1'b0, "R10 unexpected finish", int'(result_o), -1);
                else begin
                    automatic logic [1:0] r = res_q.pop_front();
                    check(result_o == r, "R10 result code", int'(result_o), int'(r));
                end
            end
            if (s_ready_o) ready_cnt++;
            if (init_i && !init_prev) init_rise_cyc = cyc;
            if (s_ready_o && !ready_prev && init_rise_cyc >= 0)
                check(cyc - init_rise_cyc == 2, "R3 init sync latency",
                      cyc - init_rise_cyc, 2);
            if (!cfg_prog_n_o) low_run++;
            if (cfg_prog_n_o && !prog_prev) begin
                check(low_run == PROG, "R2 program pulse width", low_run, PROG);
                low_run = 0;
            end
        end
        init_prev  = init_i;
        ready_prev = s_ready_o;
        prog_prev  = cfg_prog_n_o;
    end

    // Byte source driver; pushes each accepted byte to the scoreboard.
    task automatic push_stream(input int n, input int gap, input int seed);
        for (int i = 0; i < n; i++) begin
            automatic logic [DATA_W-1:0] v = DATA_W'(seed + i * 37);
            if (gap > 0 && i > 0) begin
                s_valid_i = 1'b0;
                repeat (gap) @(negedge clk);
                #1;
            end
            s_valid_i = 1'b1;
            s_data_i  = v;
            while (!s_ready_o) begin @(negedge clk); #1; end
            exp_q.push_back(v);
            @(negedge clk); #1;
        end
        s_valid_i = 1'b0;
    endtask

    // One load; called half a cycle away from the rising edge.
    task automatic run_load(input int size, input int gap, input bit init_ok,
                            input bit done_ok, input logic [1:0] code, input bit poke);
        int fin0, str0, rdy0, cnt;
        fin0 = fin_cnt; str0 = strobe_cnt; rdy0 = ready_cnt;
        done_go = 1'b0;
        init_ena = init_ok;
        space_present_i = 1'b1;
        start_i = 1'b1;
        size_i = SIZE_W'(size);
        res_q.push_back(code);
        @(negedge clk);
        cnt = 1;
        start_i = 1'b0;
        check(busy_o == 1'b1 && cfg_prog_n_o == 1'b0, "R11 start accepted", int'(busy_o), 1);
        if (poke) begin
            @(negedge clk); cnt++;
            start_i = 1'b1; size_i = 8'd7;
            @(negedge clk); cnt++;
            start_i = 1'b0;
        end
        if (code == 2'd2) begin
            s_valid_i = 1'b1;
        end else begin
            push_stream(size, gap, size * 11 + gap);
            if (done_ok) done_go = 1'b1;
        end
        while (!finish_o) begin @(negedge clk); cnt++; end
        s_valid_i = 1'b0;
        #1;
        if (code == 2'd2) begin
            check(cnt == PROG + ITMO + 1, "R4 init timeout timing", cnt, PROG + ITMO + 1);
            check(ready_cnt == rdy0, "R4 no byte taken", ready_cnt - rdy0, 0);
        end
        check(strobe_cnt - str0 == ((code == 2'd2) ? 0 : size), "R5 byte count",
              strobe_cnt - str0, (code == 2'd2) ? 0 : size);
        check(fin_cnt - fin0 == 1, "R10 one finish", fin_cnt - fin0, 1);
        check(!busy_o && !cfg_en_o && cfg_prog_n_o, "R1 lines released at exit",
              int'(cfg_en_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && cfg_prog_n_o && !cfg_en_o && !finish_o && !s_ready_o && !cfg_wr_o,
              "R10 reset state", int'(busy_o), 0);

        // R9: abort with no configuration space.
        #1;
        space_present_i = 1'b0;
        start_i = 1'b1;
        res_q.push_back(2'd1);
        @(negedge clk);
        start_i = 1'b0;
        check(finish_o && !busy_o && cfg_prog_n_o && !cfg_en_o, "R9 abort quiet",
              int'(finish_o), 1);
        @(negedge clk);
        check(!finish_o && !busy_o, "R9 R10 abort single pulse", int'(finish_o), 0);
        #1;

        // R8: plain load, continuous source.
        run_load(6, 0, 1'b1, 1'b1, 2'd0, 1'b0);
        // R6: source gaps; R11: stray start during the pulse.
        run_load(5, 2, 1'b1, 1'b1, 2'd0, 1'b1);
        // R11: start in the finish cycle of the previous load is accepted.
        run_load(3, 1, 1'b1, 1'b1, 2'd0, 1'b0);
        // R4: init never rises.
        run_load(4, 0, 1'b0, 1'b0, 2'd2, 1'b0);
        // R7: done never rises.
        run_load(3, 0, 1'b1, 1'b0, 2'd3, 1'b0);
        // R12: empty image.
        run_load(0, 0, 1'b1, 1'b1, 2'd0, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && res_q.size() == 0, "R5 R10 scoreboard drained",
              exp_q.size() + res_q.size(), 0);
        check(en_bad == 0, "R1 enable tracks busy", en_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule